// File: doc/BRIEF.md
# Three-Category Cache Miss Classifier

This unit observes the byte addresses sent to a small two-way set-associative cache with least-recently-used replacement. It tracks only tags, not data. For every access it reports whether the cache hit. For every miss it also reports the miss's cause. A miss on a block that has never been touched is compulsory. A miss that a fully associative cache of equal size would also have taken is capacity. A miss that such a cache would have served is conflict.

Three structures are consulted in parallel from their present state:
- the real tag array, four 8-byte blocks arranged as two sets of two ways;
- a shadow fully associative LRU tag store with four entries of the same block size;
- a one-bit-per-block record of every block ever referenced.

All three are updated in the same clock edge that registers the verdict. Accesses may therefore arrive on consecutive cycles. The cache allocates on writes, so loads and stores are treated alike.

Top module: `mc3c_classifier`

## Requirements
- R1: A result (res_valid_o high) appears exactly one clock cycle after each cycle in which acc_valid_i is high, and in no other cycle.
- R2: Address bits [2:0] are the byte offset and play no part in classification. Bit [3] selects the set, bits [7:4] form the tag, and bits [7:3] form the block number.
- R3: A hit in the set-associative array is reported as res_hit_o = 1 with res_class_o = 0. The class codes are 0 = hit, 1 = compulsory, 2 = capacity and 3 = conflict.
- R4: A miss on a block number never referenced since reset is reported as class 1.
- R5: A miss on a previously referenced block that would hit in the shadow fully associative LRU store of four blocks is reported as class 3.
- R6: A miss on a previously referenced block that also misses in the shadow store is reported as class 2.
- R7: Each set replaces its least recently used way. Hits refresh recency in both the real array and the shadow store, and the shadow store is updated on every access.
- R8: A store behaves exactly like a load: a store miss allocates its block.
- R9: A synchronous active-high reset empties both tag stores and the block record, and clears res_valid_o.
- R10: Cycles with acc_valid_i low change no state, whatever the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid_i | input | 1 | Access strobe |
| acc_addr_i | input | 8 | Byte address of the access |
| acc_store_i | input | 1 | 1 = store, 0 = load |
| res_valid_o | output | 1 | Verdict strobe, one cycle after the access |
| res_hit_o | output | 1 | 1 when the set-associative array hit |
| res_class_o | output | 2 | 0 hit, 1 compulsory, 2 capacity, 3 conflict |

## Verification
Every verdict is due in the cycle after its strobe, because one register stage lies between the lookup and the outputs. The bench therefore drives each access on the falling edge, waits for the next rising edge, and samples shortly after that edge. Accesses run back to back, so each verdict also shows that the previous access updated all three structures in the same edge. Tests for R10 drive an address with the strobe low for several cycles. They first check that no verdict appears, then present that address with the strobe high and check that it is still reported as compulsory.

// File: rtl/mc3c_pkg.sv
package mc3c_pkg;
    localparam int ADDR_W   = 8;
    localparam int OFF_W    = 3;
    localparam int SET_W    = 1;
    localparam int WAYS     = 2;
    localparam int SETS     = 1 << SET_W;
    localparam int TAG_W    = ADDR_W - OFF_W - SET_W;
    localparam int BLK_W    = ADDR_W - OFF_W;
    localparam int FA_DEPTH = WAYS * SETS;
    localparam int NUM_BLKS = 1 << BLK_W;

    typedef enum logic [1:0] {
        MC_HIT        = 2'd0,
        MC_COMPULSORY = 2'd1,
        MC_CAPACITY   = 2'd2,
        MC_CONFLICT   = 2'd3
    } miss_class_e;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [SET_W-1:0] set;
        logic [OFF_W-1:0] off;
    } addr_fields_t;

    function automatic miss_class_e classify(input logic real_hit,
                                             input logic seen,
                                             input logic shadow_hit);
        if (real_hit)        return MC_HIT;
        else if (!seen)      return MC_COMPULSORY;
        else if (shadow_hit) return MC_CONFLICT;
        else                 return MC_CAPACITY;
    endfunction
endpackage

// File: rtl/mc3c_lru_bank.sv
module mc3c_lru_bank #(
    parameter int ENTRIES = 2,
    parameter int KEY_W   = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             touch_i,
    input  logic [KEY_W-1:0] key_i,
    output logic             hit_o
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);

    logic [ENTRIES-1:0] valid_q;
    logic [KEY_W-1:0]   key_q [ENTRIES];
    logic [IDX_W-1:0]   age_q [ENTRIES];

    logic [ENTRIES-1:0] hit_vec;
    logic [ENTRIES-1:0] oldest_vec;
    logic [IDX_W-1:0]   hit_idx, free_idx, lru_idx, touch_idx;
    logic               has_free;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec[g]    = valid_q[g] && (key_q[g] == key_i);
        assign oldest_vec[g] = (age_q[g] == OLDEST);
    end

    assign hit_o = |hit_vec;

    always_comb begin
        hit_idx  = '0;
        lru_idx  = '0;
        free_idx = '0;
        has_free = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i])    hit_idx = IDX_W'(i);
            if (oldest_vec[i]) lru_idx = IDX_W'(i);
            if (!valid_q[i]) begin
                free_idx = IDX_W'(i);
                has_free = 1'b1;
            end
        end
        if (hit_o)         touch_idx = hit_idx;
        else if (has_free) touch_idx = free_idx;
        else               touch_idx = lru_idx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                key_q[i] <= '0;
                age_q[i] <= IDX_W'(i);
            end
        end else if (touch_i) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (IDX_W'(i) == touch_idx) begin
                    valid_q[i] <= 1'b1;
                    key_q[i]   <= key_i;
                    age_q[i]   <= '0;
                end else if (age_q[i] < age_q[touch_idx]) begin
                    age_q[i] <= age_q[i] + 1'b1;
                end
            end
        end
    end

    // R7
    hit_unique_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));

    // R7
    lru_unique_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot(oldest_vec));

    // R7
    touched_mru_chk: assert property (@(posedge clk) disable iff (rst)
        touch_i |=> (valid_q[$past(touch_idx)] &&
                     key_q[$past(touch_idx)] == $past(key_i) &&
                     age_q[$past(touch_idx)] == '0));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !touch_i |=> $stable(valid_q));
endmodule

// File: rtl/mc3c_set_assoc.sv
module mc3c_set_assoc
    import mc3c_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             touch_i,
    input  logic [SET_W-1:0] set_i,
    input  logic [TAG_W-1:0] tag_i,
    output logic             hit_o
);
    logic [SETS-1:0] set_hit;

    for (genvar s = 0; s < SETS; s++) begin : g_set
        mc3c_lru_bank #(
            .ENTRIES (WAYS),
            .KEY_W   (TAG_W)
        ) bank_i (
            .clk     (clk),
            .rst     (rst),
            .touch_i (touch_i && (set_i == SET_W'(s))),
            .key_i   (tag_i),
            .hit_o   (set_hit[s])
        );
    end

    assign hit_o = set_hit[set_i];
endmodule

// File: rtl/mc3c_seen_rec.sv
module mc3c_seen_rec
    import mc3c_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             touch_i,
    input  logic [BLK_W-1:0] blk_i,
    output logic             seen_o
);
    logic [NUM_BLKS-1:0] seen_q;

    assign seen_o = seen_q[blk_i];

    always_ff @(posedge clk) begin
        if (rst)          seen_q <= '0;
        else if (touch_i) seen_q[blk_i] <= 1'b1;
    end

    // R4
    mark_seen_chk: assert property (@(posedge clk) disable iff (rst)
        touch_i |=> seen_q[$past(blk_i)]);

    // R10
    seen_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !touch_i |=> $stable(seen_q));

    // R4
    seen_grow_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(seen_q) <= $countones($past(seen_q)) + 1);
endmodule

// File: rtl/mc3c_classifier.sv
module mc3c_classifier
    import mc3c_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid_i,
    input  logic [ADDR_W-1:0] acc_addr_i,
    input  logic              acc_store_i,
    output logic              res_valid_o,
    output logic              res_hit_o,
    output logic [1:0]        res_class_o
);
    addr_fields_t fld;
    logic [BLK_W-1:0] blk;
    logic real_hit, shadow_hit, seen;
    miss_class_e cls_d, cls_q;
    logic valid_q, hit_q;

    assign fld = addr_fields_t'(acc_addr_i);
    assign blk = {fld.tag, fld.set};

    mc3c_set_assoc real_i (
        .clk     (clk),
        .rst     (rst),
        .touch_i (acc_valid_i),
        .set_i   (fld.set),
        .tag_i   (fld.tag),
        .hit_o   (real_hit)
    );

    mc3c_lru_bank #(
        .ENTRIES (FA_DEPTH),
        .KEY_W   (BLK_W)
    ) shadow_i (
        .clk     (clk),
        .rst     (rst),
        .touch_i (acc_valid_i),
        .key_i   (blk),
        .hit_o   (shadow_hit)
    );

    mc3c_seen_rec seen_i (
        .clk     (clk),
        .rst     (rst),
        .touch_i (acc_valid_i),
        .blk_i   (blk),
        .seen_o  (seen)
    );

    assign cls_d = classify(real_hit, seen, shadow_hit);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            hit_q   <= 1'b0;
            cls_q   <= MC_HIT;
        end else begin
            valid_q <= acc_valid_i;
            if (acc_valid_i) begin
                hit_q <= real_hit;
                cls_q <= cls_d;
            end
        end
    end

    assign res_valid_o = valid_q;
    assign res_hit_o   = hit_q;
    assign res_class_o = cls_q;

    // R1
    res_due_chk: assert property (@(posedge clk) disable iff (rst)
        acc_valid_i |=> res_valid_o);

    // R1
    res_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !acc_valid_i |=> !res_valid_o);

    // R3
    hit_code_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid_o |-> (res_hit_o == (res_class_o == 2'd0)));

    // R4
    first_touch_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid_i && !seen) |-> !real_hit && !shadow_hit);

    // R8
    store_alloc_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid_i && acc_store_i) |=> res_valid_o);
endmodule

// File: tb/mc3c_classifier_tb_top.sv
module mc3c_classifier_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       acc_valid_i;
    logic [7:0] acc_addr_i;
    logic       acc_store_i;
    logic       res_valid_o;
    logic       res_hit_o;
    logic [1:0] res_class_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    localparam logic [1:0] H = 2'd0, COMP = 2'd1, CAP = 2'd2, CONF = 2'd3;

    always #2 clk = ~clk;

    mc3c_classifier dut_i (
        .clk         (clk),
        .rst         (rst),
        .acc_valid_i (acc_valid_i),
        .acc_addr_i  (acc_addr_i),
        .acc_store_i (acc_store_i),
        .res_valid_o (res_valid_o),
        .res_hit_o   (res_hit_o),
        .res_class_o (res_class_o)
    );

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; acc_valid_i = 1'b0; acc_addr_i = '0; acc_store_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // One access; verdict sampled 1 ns after the next rising edge.
    task automatic do_access(input string req, input logic [7:0] a,
                             input logic st, input logic [1:0] exp_cls);
        @(negedge clk);
        acc_valid_i = 1'b1; acc_addr_i = a; acc_store_i = st;
        @(posedge clk);
        #1;
        check(req, {1'b0, res_valid_o, res_class_o},
                   {1'b0, 1'b1, exp_cls});
        check("R3", {3'b0, res_hit_o}, {3'b0, exp_cls == H});
    endtask

    task automatic go_idle(input logic [7:0] a, input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            acc_valid_i = 1'b0; acc_addr_i = a;
            @(posedge clk);
            #1;
            check("R1 quiet", {3'b0, res_valid_o}, 4'h0);
        end
    endtask

    task automatic t_reset_state();
        do_reset();
        #1;
        check("R9 reset valid", {3'b0, res_valid_o}, 4'h0);
    endtask

    task automatic t_mixed_stream();
        do_reset();
        do_access("R4", 8'h10, 1'b0, COMP);
        do_access("R4", 8'h18, 1'b0, COMP);
        do_access("R8", 8'h20, 1'b1, COMP);
        do_access("R8", 8'h30, 1'b1, COMP);
        do_access("R3", 8'h18, 1'b0, H);
        do_access("R5", 8'h10, 1'b0, CONF);
        do_access("R7", 8'h30, 1'b1, H);
        do_access("R4", 8'h28, 1'b0, COMP);
        do_access("R6", 8'h20, 1'b1, CAP);
        do_access("R7", 8'h18, 1'b1, H);
        do_access("R6", 8'h10, 1'b0, CAP);
        do_access("R2 offset", 8'h13, 1'b0, H);
        do_access("R2 offset", 8'h25, 1'b0, H);
        go_idle(8'h00, 1);
    endtask

    task automatic t_lru_order();
        do_reset();
        do_access("R4", 8'h00, 1'b0, COMP);
        do_access("R4", 8'h40, 1'b0, COMP);
        do_access("R7", 8'h00, 1'b0, H);
        do_access("R4", 8'h80, 1'b0, COMP);
        do_access("R7", 8'h07, 1'b0, H);
        do_access("R5", 8'h40, 1'b0, CONF);
        go_idle(8'h00, 1);
    endtask

    task automatic t_store_alloc();
        do_reset();
        do_access("R8", 8'h50, 1'b1, COMP);
        do_access("R8", 8'h57, 1'b0, H);
        go_idle(8'h00, 1);
    endtask

    task automatic t_idle_ignored();
        do_reset();
        go_idle(8'h60, 4);
        do_access("R10", 8'h60, 1'b0, COMP);
        go_idle(8'h00, 1);
    endtask

    task automatic t_reset_clears();
        do_reset();
        do_access("R4", 8'h10, 1'b0, COMP);
        do_access("R3", 8'h10, 1'b0, H);
        do_reset();
        do_access("R9", 8'h10, 1'b0, COMP);
        go_idle(8'h00, 1);
    endtask

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; acc_valid_i = 1'b0; acc_addr_i = '0; acc_store_i = 1'b0;
        t_reset_state();
        t_mixed_stream();
        t_lru_order();
        t_store_alloc();
        t_idle_ignored();
        t_reset_clears();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule